// File: doc/BRIEF.md
# Programmable Reversible Control Gate

This block maps a K-bit word to another K-bit word through a reversible control gate. Output bit i is input bit i XORed with a Boolean function of the bits below it. Bit 0 has no lower bits, so it is XORed with a single constant. Each of these functions is a truth table held in registers and loaded one entry per clock through a write port. The tables reset to all zeros, which makes the gate the identity mapping.

Internally the gate is a chain of simple stages, and each stage changes exactly one bit. In forward mode the chain runs from the top bit down to bit 0, so every table reads the original lower bits. A general control gate is not its own inverse. For that reason a direction input selects an inverse mode, which runs the same stages from bit 0 upward and undoes the forward mapping.

Evaluation is purely combinational. The data path carries a valid/ready pair that passes straight through the block: it holds no data and does not stall. A stall on the output side shows up on the input side in the same cycle, and a word counts as transferred only when both valid and ready are high.

Top module: `rcg_gate`

## Requirements
- R1: After reset every table bit is 0, so out_data equals in_data in both directions.
- R2: With dir_inv = 0, out_data[i] = in_data[i] XOR T_i[in_data[i-1:0]] for i >= 1, and out_data[0] = in_data[0] XOR T_0[0].
- R3: With dir_inv = 1, out_data is the word y with y[0] = in_data[0] XOR T_0[0] and y[i] = in_data[i] XOR T_i[y[i-1:0]], evaluated from bit 0 upward.
- R4: Feeding the forward result back with dir_inv = 1 returns the original word, for any table contents.
- R5: Entry j of table T_i sits at flat configuration address 2^i - 1 + j, and table T_i has 2^i entries.
- R6: When cfg_we is 1 at a rising clk edge, cfg_bit is stored at cfg_addr on that edge. The output in the cycle of the write still uses the old contents.
- R7: A write to address 2^K - 1 (all ones) changes no table bit.
- R8: out_valid follows in_valid and in_ready follows out_ready in the same cycle, with no storage in between.
- R9: While cfg_we is 0, changes on cfg_addr and cfg_bit change no table bit.
- R10: For fixed tables and direction, the 2^K input words map to 2^K distinct output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears all tables |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | K | Flat table entry address |
| cfg_bit | input | 1 | Value written to the addressed entry |
| dir_inv | input | 1 | 0 = forward mapping, 1 = inverse mapping |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input may be accepted (follows out_ready) |
| in_data | input | K | Input word |
| out_valid | output | 1 | Output word valid (follows in_valid) |
| out_ready | input | 1 | Downstream ready |
| out_data | output | K | Mapped output word |

## Verification
A table write and a live evaluation can fall in the same cycle, and that overlap gets a directed test. The test drives a write that flips entry 0 of table 0 together with an input word that uses that entry. Before the clock edge the output must match the old tables; after the edge the bench expects the flipped bit. Random table loads then interleave writes with evaluation in both directions, and every output is compared with bench-side forward and inverse models. The bench also checks the round trip and that the mapping is a bijection over all words.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } rcg_dir_e;

  // first flat address of table idx
  function automatic int tt_base(input int idx);
    return (1 << idx) - 1;
  endfunction
endpackage

// File: rtl/rcg_tt_store.sv
module rcg_tt_store #(
  parameter int K = 4,
  localparam int NENT = (1 << K) - 1,
  localparam int AW = K
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic            wbit,
  output logic [NENT-1:0] tt
);
  logic [NENT-1:0] tt_q;
  logic            hit;

  // the all-ones address lies past the last entry and is dropped
  assign hit = we && (addr != {AW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tt_q <= '0;
    end else if (hit) begin
      tt_q[addr] <= wbit;
    end
  end

  assign tt = tt_q;
endmodule

// File: rtl/rcg_stage.sv
module rcg_stage #(
  parameter int K = 4,
  parameter int IDX = 0,
  localparam int SZ = 1 << IDX
) (
  input  logic [K-1:0]  d,
  input  logic [SZ-1:0] tt,
  output logic [K-1:0]  q
);
  logic sel;

  generate
    if (IDX == 0) begin : g_const
      assign sel = tt[0];
    end else begin : g_lookup
      assign sel = tt[d[IDX-1:0]];
    end
  endgenerate

  always_comb begin
    q      = d;
    q[IDX] = d[IDX] ^ sel;
  end
endmodule

// File: rtl/rcg_gate.sv
module rcg_gate
  import rcg_pkg::*;
#(
  parameter int K = 4,
  localparam int NENT = (1 << K) - 1,
  localparam int AW = K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cfg_bit,
  input  logic          dir_inv,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [K-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [K-1:0]  out_data
);
  logic [NENT-1:0] tt;
  logic [K-1:0]    fwd_w [0:K];
  logic [K-1:0]    inv_w [0:K];

  rcg_tt_store #(.K(K)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wbit (cfg_bit),
    .tt   (tt)
  );

  assign fwd_w[K] = in_data;
  assign inv_w[0] = in_data;

  generate
    for (genvar i = 0; i < K; i++) begin : g_stage
      localparam int BASE = tt_base(i);
      localparam int SZ   = 1 << i;
      // forward: top bit first, so each table sees original lower bits
      rcg_stage #(.K(K), .IDX(i)) u_fwd (
        .d (fwd_w[i+1]),
        .tt(tt[BASE+SZ-1:BASE]),
        .q (fwd_w[i])
      );
      // inverse: bit 0 first, each table sees already-restored lower bits
      rcg_stage #(.K(K), .IDX(i)) u_inv (
        .d (inv_w[i]),
        .tt(tt[BASE+SZ-1:BASE]),
        .q (inv_w[i+1])
      );
    end
  endgenerate

  assign out_data  = (rcg_dir_e'(dir_inv) == DIR_INV) ? inv_w[K] : fwd_w[0];
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic [K-1:0] cfg_addr,
  input logic         dir_inv,
  input logic         in_valid,
  input logic         in_ready,
  input logic [K-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [K-1:0] out_data
);
  // R1: the edge leaving reset sees cleared tables
  a_r1_reset_identity: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_data == in_data));

  // R7 / R9: with no effective write, steady inputs give a steady output
  a_r9_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || (&cfg_addr)) |=>
      (!($stable(in_data) && $stable(dir_inv)) || $stable(out_data)));

  // R10: with the mapping fixed, a new input word gives a new output word
  a_r10_injective: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || (&cfg_addr)) |=>
      (!($stable(dir_inv) && !$stable(in_data)) || !$stable(out_data)));

  // R8: an input stall never coincides with an output transfer
  a_r8_no_hidden_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> !(out_valid && out_ready));
endmodule

bind rcg_gate rcg_checker #(.K(K)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .dir_inv  (dir_inv),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/rcg_gate_tb.sv
module rcg_gate_tb;
  localparam int K = 4;
  localparam int NENT = (1 << K) - 1;
  localparam int NW = 1 << K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [K-1:0] cfg_addr = '0;
  logic         cfg_bit = 1'b0;
  logic         dir_inv = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [K-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [K-1:0] out_data;

  logic [NENT-1:0] model = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rcg_gate #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_bit(cfg_bit), .dir_inv(dir_inv), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int lut(input int i, input logic [K-1:0] low);
    int j = int'(low) & ((1 << i) - 1);
    return int'(model[(1 << i) - 1 + j]);
  endfunction

  function automatic logic [K-1:0] ref_fwd(input logic [K-1:0] x);
    logic [K-1:0] y = x;
    for (int i = 0; i < K; i++) y[i] = x[i] ^ lut(i, x)[0];
    return y;
  endfunction

  function automatic logic [K-1:0] ref_inv(input logic [K-1:0] x);
    logic [K-1:0] y = '0;
    for (int i = 0; i < K; i++) y[i] = x[i] ^ lut(i, y)[0];
    return y;
  endfunction

  task automatic check(input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [K-1:0] a, input logic b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_bit = b;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a != {K{1'b1}}) model[a] = b;
  endtask

  task automatic eval(input logic [K-1:0] x, input logic d);
    @(negedge clk);
    in_data = x; dir_inv = d;
    #2;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [K-1:0] fw;
    logic [NW-1:0] seen;
    logic [NENT-1:0] snap;
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: identity after reset
    for (int x = 0; x < NW; x++) begin
      eval(K'(x), 1'b0); check("R1 fwd", out_data, K'(x));
      eval(K'(x), 1'b1); check("R1 inv", out_data, K'(x));
    end

    // R8: handshake passes straight through
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      in_valid = c[0]; out_ready = c[1];
      #2;
      check("R8 valid", {{(K-1){1'b0}}, out_valid}, {{(K-1){1'b0}}, c[0]});
      check("R8 ready", {{(K-1){1'b0}}, in_ready}, {{(K-1){1'b0}}, c[1]});
    end
    in_valid = 1'b1; out_ready = 1'b1;

    // R5: entry 3 of table 2 is flat address 6; only words with low bits 3 flip bit 2
    wr(K'(6), 1'b1);
    for (int x = 0; x < NW; x++) begin
      eval(K'(x), 1'b0);
      check("R5 layout", out_data, K'(x) ^ (((x & 3) == 3) ? K'(4) : K'(0)));
    end

    // R6: write and evaluation in the same cycle
    @(negedge clk);
    in_data = '0; dir_inv = 1'b0;
    cfg_we = 1'b1; cfg_addr = '0; cfg_bit = ~model[0];
    #2 check("R6 old contents", out_data, ref_fwd('0));
    @(posedge clk);
    #1 cfg_we = 1'b0;
    model[0] = ~model[0];
    #1 check("R6 new contents", out_data, ref_fwd('0));
    check("R6 bit0 flipped", out_data, {{(K-1){1'b0}}, model[0]});

    // R7: all-ones address changes nothing
    snap = model;
    wr({K{1'b1}}, 1'b1);
    wr({K{1'b1}}, 1'b0);
    for (int x = 0; x < NW; x++) begin
      eval(K'(x), 1'b0);
      check("R7 ignored addr", out_data, ref_fwd(K'(x)));
    end
    if (model != snap) $display("bench model changed unexpectedly");

    // R9: address and data wiggle with write enable low
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      cfg_addr = K'($urandom); cfg_bit = 1'($urandom);
    end
    for (int x = 0; x < NW; x++) begin
      eval(K'(x), 1'b1);
      check("R9 no write", out_data, ref_inv(K'(x)));
    end

    // R2 R3 R4 R10: random table loads
    for (int cfg = 0; cfg < 24; cfg++) begin
      for (int a = 0; a < NENT; a++)
        if (($urandom % 2) == 0 || cfg < 2) wr(K'(a), 1'($urandom));
      seen = '0;
      for (int x = 0; x < NW; x++) begin
        eval(K'(x), 1'b0);
        check("R2 forward", out_data, ref_fwd(K'(x)));
        fw = out_data;
        seen[fw] = 1'b1;
        eval(fw, 1'b1);
        check("R4 round trip", out_data, K'(x));
        eval(K'(x), 1'b1);
        check("R3 inverse", out_data, ref_inv(K'(x)));
      end
      check("R10 bijection", K'($countones(seen) & (NW - 1)), K'(NW & (NW - 1)));
      checks++;
      if (seen != {NW{1'b1}}) begin
        fails++;
        $display("FAIL R10: got %h expected all ones", seen);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule